// File: doc/BRIEF.md
# Text-Mode Raster Display Controller

This block turns a grid of character codes into a VGA-style raster. A character-code memory is filled through a small request/acknowledge port that runs on the system clock. The display side runs on a separate dot clock, nominally 25 MHz. It walks the raster with horizontal and vertical counters, fetches the code for each 8x16 cell, and turns the code into one glyph row. The row is then shifted out one pixel per dot clock on identical red, green and blue buses. Both syncs are active low.

The display path is a two-stage pipeline. Both stages advance on an enable that pulses on the last dot of every 8-dot cell. The first stage latches the cell's code and scanline. The second stage loads the glyph row into an 8-bit shift register. Display enable is carried through the same two stages, so it lines up with the pixels it qualifies.

The glyph pattern is computed, not stored. Code zero always gives a blank row. The raster timing and the grid size are parameters. The defaults give 640x480 visible pixels in an 800x525 frame, which is an 80x30 grid.

Top module: `vga_text_ctrl`

## Requirements
- R1: While rst_n is low, hs_n and vs_n are 1, de is 0, red/green/blue are 0 and ack is 0.
- R2: The line is H_ACTIVE+H_FRONT+H_SYNC+H_BACK dots long. hs_n is 0 exactly on dots H_ACTIVE+H_FRONT through H_ACTIVE+H_FRONT+H_SYNC-1 of every line, and 1 elsewhere.
- R3: The frame is V_ACTIVE+V_FRONT+V_SYNC+V_BACK lines long. vs_n is 0 for all dots of lines V_ACTIVE+V_FRONT through V_ACTIVE+V_FRONT+V_SYNC-1, and 1 elsewhere. vs_n therefore changes only on dot 0 of a line, while hs_n is 1.
- R4: de at raster position p (p = line*line_length + dot) equals the visibility of position p-16, taken modulo the frame length. Position q is visible when its dot is below H_ACTIVE and its line is below V_ACTIVE. This is a delay of two 8-dot cells.
- R5: For a visible delayed position q (dot x, line y), the pixel uses the code stored at memory address (y/16)*(H_ACTIVE/8) + x/8 and the glyph row for scanline s = y mod 16. The glyph row is the code rotated left by s[2:0] when s[3]=0, and rotated right by s[2:0] when s[3]=1. Bit 7-(x mod 8) is the pixel, so the most significant bit is shown first. A 1 drives 8'hFF and a 0 drives 8'h00.
- R6: A cell holding code 8'h00 is blank on every scanline.
- R7: Whenever de is 0, red, green and blue are 0.
- R8: A request (req=1 while ack=0) sampled on a sys_clk edge performs the access, and ack is 1 for exactly the following cycle. When we=1 the access is a write of wdata to addr.
- R9: When we=0, rdata holds the byte at addr during the ack cycle. It holds that value until the next read.
- R10: With req=0, no access takes place: ack stays 0 and the memory is unchanged. ack is never high on two consecutive cycles.
- R11: An address at or above (H_ACTIVE/8)*(V_ACTIVE/16) is still acknowledged. A write to it is dropped, and a read of it returns 8'h00.
- R12: red, green and blue are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Processor-side clock |
| dot_clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| req | input | 1 | Access request, active high |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Character memory address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with ack |
| ack | output | 1 | One-cycle access acknowledge |
| red | output | 8 | Red pixel level |
| green | output | 8 | Green pixel level |
| blue | output | 8 | Blue pixel level |
| hs_n | output | 1 | Horizontal sync, active low |
| vs_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Display enable, aligned with pixels |

## Verification
The hardest thing to reach from the ports is a known alignment between the observed pixel stream and raster position. The counters start at reset in a clock domain the processor port does not share. The bench therefore locks onto the first falling edge of vs_n, which by R3 marks dot 0 of a known line. From there it predicts every dot of two full frames from its own copy of the memory contents. The memory contents include directed code-zero and extreme codes placed at row and line ends, so the wrap of the two-cell delay across lines and frames is exercised. Out-of-range writes and idle cycles with req low are placed before the raster check, so any stray write shows up both in read-back and on screen.

// File: rtl/vga_text_pkg.sv
`timescale 1ns/1ps
package vga_text_pkg;

  localparam int CELL_W = 8;
  localparam int CELL_H = 16;
  localparam int PORT_AW = 12;

  typedef logic [7:0] byte_t;

  // Glyph row generator: rotation of the code, direction chosen by scanline bit 3.
  // A zero code yields a zero row on every scanline.
  function automatic byte_t glyph_row(input byte_t code, input logic [3:0] scan);
    logic [15:0] dbl;
    dbl = {code, code};
    if (scan[3]) begin
      dbl = dbl >> scan[2:0];
      return dbl[7:0];
    end
    dbl = dbl << scan[2:0];
    return dbl[15:8];
  endfunction

endpackage

// File: rtl/vga_rst_sync.sv
`timescale 1ns/1ps
module vga_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stg;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg <= 2'b00;
    else         stg <= {stg[0], 1'b1};
  end

  assign srst_n = stg[1];
endmodule

// File: rtl/vga_raster_timing.sv
`timescale 1ns/1ps
module vga_raster_timing #(
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 33
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        cell_end,
  output logic        vis,
  output logic [3:0]  scan,
  output logic [11:0] cell_addr,
  output logic        hs_n,
  output logic        vs_n
);
  import vga_text_pkg::*;

  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam int COLS = H_ACTIVE / CELL_W;
  localparam logic [HW-1:0] H_LAST   = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST   = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] H_VIS    = HW'(H_ACTIVE);
  localparam logic [VW-1:0] V_VIS    = VW'(V_ACTIVE);
  localparam logic [HW-1:0] HS_BEG   = HW'(H_ACTIVE + H_FRONT);
  localparam logic [HW-1:0] HS_END   = HW'(H_ACTIVE + H_FRONT + H_SYNC);
  localparam logic [VW-1:0] VS_BEG   = VW'(V_ACTIVE + V_FRONT);
  localparam logic [VW-1:0] VS_END   = VW'(V_ACTIVE + V_FRONT + V_SYNC);

  logic [HW-1:0] h_cnt, h_nxt;
  logic [VW-1:0] v_cnt, v_nxt;

  always_comb begin
    h_nxt = h_cnt + 1'b1;
    v_nxt = v_cnt;
    if (h_cnt == H_LAST) begin
      h_nxt = '0;
      v_nxt = (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else begin
      h_cnt <= h_nxt;
      v_cnt <= v_nxt;
    end
  end

  assign cell_end  = (h_cnt[2:0] == 3'd7);
  assign vis       = (h_cnt < H_VIS) && (v_cnt < V_VIS);
  assign scan      = v_cnt[3:0];
  assign cell_addr = 12'(v_cnt >> 4) * 12'(COLS) + 12'(h_cnt >> 3);
  assign hs_n      = !((h_cnt >= HS_BEG) && (h_cnt < HS_END));
  assign vs_n      = !((v_cnt >= VS_BEG) && (v_cnt < VS_END));
endmodule

// File: rtl/vga_char_mem.sv
`timescale 1ns/1ps
module vga_char_mem #(
  parameter int DEPTH = 2400
) (
  input  logic        sys_clk,
  input  logic        sys_rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [11:0] addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        ack,
  input  logic        dot_clk,
  input  logic [11:0] disp_addr,
  output logic [7:0]  disp_code
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [12:0] LIMIT = 13'(DEPTH);

  logic [7:0] mem [DEPTH];
  logic       take, cpu_ok, disp_ok;
  logic       ack_nxt;
  logic [7:0] rdata_nxt;

  assign take    = req && !ack;
  assign cpu_ok  = ({1'b0, addr} < LIMIT);
  assign disp_ok = ({1'b0, disp_addr} < LIMIT);

  always_comb begin
    ack_nxt   = take;
    rdata_nxt = rdata;
    if (take && !we) rdata_nxt = cpu_ok ? mem[addr[IW-1:0]] : 8'h00;
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      ack   <= 1'b0;
      rdata <= 8'h00;
    end else begin
      ack   <= ack_nxt;
      rdata <= rdata_nxt;
    end
  end

  always_ff @(posedge sys_clk) begin
    if (sys_rst_n && take && we && cpu_ok) mem[addr[IW-1:0]] <= wdata;
  end

  always_ff @(posedge dot_clk) begin
    disp_code <= disp_ok ? mem[disp_addr[IW-1:0]] : 8'h00;
  end
endmodule

// File: rtl/vga_cell_pipe.sv
`timescale 1ns/1ps
module vga_cell_pipe (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cell_end,
  input  logic       vis,
  input  logic [3:0] scan,
  input  logic [7:0] code_in,
  output logic       de,
  output logic       pix
);
  import vga_text_pkg::*;

  byte_t      code_q, code_n;
  logic [3:0] scan_q, scan_n;
  logic       vis_q1, vis_n1;
  byte_t      shreg, shreg_n;
  logic       vis_q2, vis_n2;

  always_comb begin
    code_n  = code_q;
    scan_n  = scan_q;
    vis_n1  = vis_q1;
    vis_n2  = vis_q2;
    shreg_n = {shreg[6:0], 1'b0};
    if (cell_end) begin
      code_n  = code_in;
      scan_n  = scan;
      vis_n1  = vis;
      shreg_n = glyph_row(code_q, scan_q);
      vis_n2  = vis_q1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      scan_q <= '0;
      vis_q1 <= 1'b0;
      shreg  <= '0;
      vis_q2 <= 1'b0;
    end else begin
      code_q <= code_n;
      scan_q <= scan_n;
      vis_q1 <= vis_n1;
      shreg  <= shreg_n;
      vis_q2 <= vis_n2;
    end
  end

  assign de  = vis_q2;
  assign pix = vis_q2 & shreg[7];
endmodule

// File: rtl/vga_text_ctrl.sv
`timescale 1ns/1ps
module vga_text_ctrl #(
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 33
) (
  input  logic        sys_clk,
  input  logic        dot_clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [11:0] addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        ack,
  output logic [7:0]  red,
  output logic [7:0]  green,
  output logic [7:0]  blue,
  output logic        hs_n,
  output logic        vs_n,
  output logic        de
);
  import vga_text_pkg::*;

  localparam int DEPTH = (H_ACTIVE / CELL_W) * (V_ACTIVE / CELL_H);

  logic        sys_rst_n, dot_rst_n;
  logic        cell_end, vis, pix;
  logic [3:0]  scan;
  logic [11:0] cell_addr;
  logic [7:0]  cell_code;

  vga_rst_sync u_rs_sys (.clk(sys_clk), .arst_n(rst_n), .srst_n(sys_rst_n));
  vga_rst_sync u_rs_dot (.clk(dot_clk), .arst_n(rst_n), .srst_n(dot_rst_n));

  vga_raster_timing #(
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK)
  ) u_tim (
    .clk(dot_clk), .rst_n(dot_rst_n), .cell_end(cell_end), .vis(vis),
    .scan(scan), .cell_addr(cell_addr), .hs_n(hs_n), .vs_n(vs_n)
  );

  vga_char_mem #(.DEPTH(DEPTH)) u_mem (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .req(req), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ack(ack),
    .dot_clk(dot_clk), .disp_addr(cell_addr), .disp_code(cell_code)
  );

  vga_cell_pipe u_pipe (
    .clk(dot_clk), .rst_n(dot_rst_n), .cell_end(cell_end), .vis(vis),
    .scan(scan), .code_in(cell_code), .de(de), .pix(pix)
  );

  assign red   = {8{pix}};
  assign green = {8{pix}};
  assign blue  = {8{pix}};
endmodule

// File: rtl/vga_text_ctrl_chk.sv
`timescale 1ns/1ps
module vga_text_ctrl_chk (
  input logic       sys_clk,
  input logic       dot_clk,
  input logic       rst_n,
  input logic       req,
  input logic       ack,
  input logic [7:0] red,
  input logic [7:0] green,
  input logic [7:0] blue,
  input logic       hs_n,
  input logic       vs_n,
  input logic       de
);
  // R8 / R10: acknowledge lasts one cycle
  p_ack_single_r10: assert property (@(posedge sys_clk) disable iff (!rst_n)
    ack |=> !ack);

  // R10: no acknowledge without a request in the cycle before
  p_ack_from_req_r8: assert property (@(posedge sys_clk) disable iff (!rst_n)
    ack |-> $past(req));

  // R7: blanking outside display enable
  p_blank_r7: assert property (@(posedge dot_clk) disable iff (!rst_n)
    !de |-> (red == 8'h00 && green == 8'h00 && blue == 8'h00));

  // R12: colour buses agree
  p_rgb_equal_r12: assert property (@(posedge dot_clk) disable iff (!rst_n)
    (red == green) && (green == blue));

  // R5: only full-on or full-off levels
  p_rgb_level_r5: assert property (@(posedge dot_clk) disable iff (!rst_n)
    (red == 8'h00) || (red == 8'hFF));

  // R3: vertical sync changes only outside horizontal sync
  p_vs_edge_r3: assert property (@(posedge dot_clk) disable iff (!rst_n)
    !$stable(vs_n) |-> hs_n);

  // R2: horizontal sync pulse is longer than one dot
  p_hs_width_r2: assert property (@(posedge dot_clk) disable iff (!rst_n)
    $fell(hs_n) |=> !hs_n);
endmodule

bind vga_text_ctrl vga_text_ctrl_chk u_chk (
  .sys_clk(sys_clk), .dot_clk(dot_clk), .rst_n(rst_n), .req(req), .ack(ack),
  .red(red), .green(green), .blue(blue), .hs_n(hs_n), .vs_n(vs_n), .de(de)
);

// File: tb/vga_text_ctrl_tb.sv
`timescale 1ns/1ps
module vga_text_ctrl_tb;
  localparam int HA = 64, HF = 8, HS = 16, HB = 8;
  localparam int VA = 32, VF = 2, VS = 2, VB = 3;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FT = HT * VT;
  localparam int COLS = HA / 8;
  localparam int CELLS = COLS * (VA / 16);

  logic sys_clk = 1'b0, dot_clk = 1'b0, rst_n;
  logic req, we;
  logic [11:0] addr;
  logic [7:0] wdata, rdata, red, green, blue;
  logic ack, hs_n, vs_n, de;

  int n_tests = 0, n_fail = 0;
  logic [7:0] shadow [CELLS];

  always #5  sys_clk = ~sys_clk;
  always #20 dot_clk = ~dot_clk;

  vga_text_ctrl #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB)
  ) u_dut (
    .sys_clk(sys_clk), .dot_clk(dot_clk), .rst_n(rst_n), .req(req), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ack(ack), .red(red),
    .green(green), .blue(blue), .hs_n(hs_n), .vs_n(vs_n), .de(de)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_glyph(input logic [7:0] c, input int s);
    logic [7:0] r;
    int k;
    r = c;
    k = s % 8;
    for (int i = 0; i < k; i++) begin
      if (s >= 8) r = {r[0], r[7:1]};
      else        r = {r[6:0], r[7]};
    end
    return r;
  endfunction

  task automatic xfer(input logic w, input logic [11:0] a, input logic [7:0] d,
                      output logic [7:0] q);
    @(negedge sys_clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge sys_clk);
    check(ack == 1'b1, "R8 ack after request", int'(ack), 1);
    q = rdata;
    req = 1'b0;
    @(negedge sys_clk);
    check(ack == 1'b0, "R8 ack single cycle", int'(ack), 0);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] q;
    logic prev_vs;
    int pos;
    void'($urandom(32'd20251));
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge dot_clk);
    // R1 reset state
    check(hs_n == 1'b1 && vs_n == 1'b1, "R1 syncs in reset", {hs_n, vs_n}, 3);
    check(de == 1'b0 && red == 8'h00 && green == 8'h00 && blue == 8'h00,
          "R1 pixels in reset", {de, red}, 0);
    check(ack == 1'b0, "R1 ack in reset", int'(ack), 0);
    @(negedge sys_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge sys_clk);

    for (int i = 0; i < CELLS; i++) shadow[i] = 8'($urandom);
    shadow[0] = 8'h00;               // R6 directed zero at grid start
    shadow[COLS-1] = 8'hFF;          // line end, full row
    shadow[COLS] = 8'h80;
    shadow[CELLS-1] = 8'h00;         // R6 zero at grid end
    shadow[5] = 8'h01;
    for (int i = 0; i < CELLS; i++) xfer(1'b1, 12'(i), shadow[i], q);

    // R9 read back
    for (int i = 0; i < CELLS; i++) begin
      xfer(1'b0, 12'(i), 8'h00, q);
      check(q == shadow[i], "R9 read data", q, shadow[i]);
    end

    // R11 out-of-range accesses
    xfer(1'b1, 12'(CELLS), 8'hAA, q);
    xfer(1'b1, 12'hFFF, 8'h55, q);
    xfer(1'b0, 12'(CELLS), 8'h00, q);
    check(q == 8'h00, "R11 read past end", q, 0);
    xfer(1'b0, 12'hFFF, 8'h00, q);
    check(q == 8'h00, "R11 read top address", q, 0);
    xfer(1'b0, 12'h000, 8'h00, q);
    check(q == shadow[0], "R11 in-range cell untouched", q, shadow[0]);

    // R10 idle bus with write-looking inputs
    @(negedge sys_clk);
    req = 1'b0; we = 1'b1; addr = 12'd3; wdata = ~shadow[3];
    for (int i = 0; i < 6; i++) begin
      @(negedge sys_clk);
      check(ack == 1'b0, "R10 no ack while idle", int'(ack), 0);
    end
    xfer(1'b0, 12'd3, 8'h00, q);
    check(q == shadow[3], "R10 memory unchanged", q, shadow[3]);

    // lock onto start of vertical sync: dot 0 of line VA+VF (R3)
    prev_vs = 1'b1;
    forever begin
      @(negedge dot_clk);
      if (prev_vs && !vs_n) break;
      prev_vs = vs_n;
    end
    pos = (VA + VF) * HT;
    for (int k = 0; k < 2 * FT; k++) begin
      int h, v, qp, hq, vq, idx;
      logic hs_e, vs_e, de_e;
      logic [7:0] g, rgb_e;
      string tag;
      h = pos % HT; v = pos / HT;
      hs_e = !(h >= HA + HF && h < HA + HF + HS);
      vs_e = !(v >= VA + VF && v < VA + VF + VS);
      qp = (pos + FT - 16) % FT;
      hq = qp % HT; vq = qp / HT;
      de_e = (hq < HA) && (vq < VA);
      rgb_e = 8'h00;
      tag = "R7 blank";
      if (de_e) begin
        idx = (vq / 16) * COLS + hq / 8;
        g = ref_glyph(shadow[idx], vq % 16);
        rgb_e = g[7 - (hq % 8)] ? 8'hFF : 8'h00;
        tag = (shadow[idx] == 8'h00) ? "R6 zero code" : "R5 pixel";
      end
      check(hs_n == hs_e, "R2 hs_n", int'(hs_n), int'(hs_e));
      check(vs_n == vs_e, "R3 vs_n", int'(vs_n), int'(vs_e));
      check(de == de_e, "R4 de", int'(de), int'(de_e));
      check(red == rgb_e, tag, red, rgb_e);
      check(green == red && blue == red, "R12 buses equal", {green, blue}, {red, red});
      @(negedge dot_clk);
      pos = (pos + 1) % FT;
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule